// File: doc/BRIEF.md
# Serial Audio Word Receiver

This block turns a serial audio bit stream into parallel 24-bit samples. It runs on the serial bit clock and samples the data line on every rising edge. A sync input, sampled high on a rising edge, marks that edge's data bit as the most significant bit of a new slot. Each later edge before the next sync adds the next lower bit. The number of clocks in a slot is not fixed. It may be below, equal to or above the word width. The block left-justifies whatever arrived, fills the unused low bits with zeros, and drops every bit after the word is full.

A mode input chooses between the variable-length format and a fixed 16-bit format. In the 16-bit format only the first 16 bits of a slot are kept, left-justified, and the low 8 bits stay zero. The mode is captured at the slot's sync edge. When the next sync arrives, the finished word of the slot that just closed appears on the parallel output, together with a valid strobe one clock wide.

Top module: `sar_word_rx`

## Requirements
- R1: While reset is asserted and after it is released, `wordOut` is 0 and `wordValid` is low. `wordValid` stays low until one whole slot has been closed by a second sync.
- R2: Data is sampled on the rising edge of `serClk`, most significant bit first. The bit sampled with `slotSync` high lands in `wordOut[23]`, and each later bit lands one position lower.
- R3: A slot with fewer than 24 clocks has its n bits in `wordOut[23:24-n]`, and the lower bits are zero.
- R4: A slot with exactly 24 clocks fills all of `wordOut[23:0]` with the received bits, first bit in bit 23.
- R5: In 24-bit mode, bits sampled after the 24th bit of a slot are discarded and do not change the word.
- R6: Every bit inside the first 24 is stored as sampled, padding included. With 20 clocks, bits 23..4 hold the 20 samples and bits 3..0 are zero.
- R7: With `pcmMode`=1 at the sync edge, the first 16 bits go to `wordOut[23:8]`, `wordOut[7:0]` is zero, and any bits after the 16th are ignored.
- R8: `pcmMode` is sampled only on the edge where `slotSync` is high. Changes during the slot do not affect that slot's word.
- R9: On a rising edge where `slotSync` is high and a slot is open, the word of the open slot is registered into `wordOut`. `wordValid` is high for the one following cycle only, and `wordOut` holds its value in every cycle where `wordValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| serClk | input | 1 | Serial bit clock; data and sync are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| slotSync | input | 1 | High on the edge carrying the first (most significant) bit of a slot |
| serData | input | 1 | Serial data in |
| pcmMode | input | 1 | 1 selects the fixed 16-bit format, 0 the variable-length 24-bit format |
| wordOut | output | 24 | Last assembled word, left-justified |
| wordValid | output | 1 | One-cycle strobe when `wordOut` receives a new word |

## Verification
The bench builds the block with its default widths: a 24-bit word and a 16-bit fixed format. These sizes are small enough to sweep every slot length from 1 to 30 clocks in both modes, using three bit patterns: all ones, alternating bits and a pseudo-random pattern. That sweep covers the short, exact and overlong cases on both sides of each width limit. Directed slots cover the single-bit slot, the 20-clock padding case and a mode flip in the middle of a slot in both directions. The bench computes every expected word by shifting and masking the source pattern.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  // Strobes issued by the control to the datapath each serial clock
  typedef struct packed {
    logic startSlot;  // sync seen: restart the accumulator with the MSB
    logic loadBit;    // store serData at the current bit position
    logic publish;    // move the accumulator to the output register
  } sarStrobe_t;
endpackage

// File: rtl/sar_ctrl.sv
`timescale 1ns/1ps
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int PCM_W  = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic             serClk,
  input  logic             rstN,
  input  logic             slotSync,
  input  logic             pcmMode,
  output sarStrobe_t       strb,
  output logic [CNT_W-1:0] bitIdx
);
  logic             slotOpen;
  logic             pcmSlot;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] bitLimit;

  // Width limit of the current slot, fixed at its sync edge
  always_comb begin
    bitLimit = pcmSlot ? CNT_W'(PCM_W) : CNT_W'(WORD_W);
  end

  always_comb begin
    strb.startSlot = slotSync;
    strb.publish   = slotSync & slotOpen;
    strb.loadBit   = ~slotSync & slotOpen & (bitCnt < bitLimit);
    bitIdx         = bitCnt;
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      slotOpen <= 1'b0;
      pcmSlot  <= 1'b0;
      bitCnt   <= '0;
    end else if (slotSync) begin
      slotOpen <= 1'b1;
      pcmSlot  <= pcmMode;
      bitCnt   <= CNT_W'(1);
    end else if (strb.loadBit) begin
      bitCnt   <= bitCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/sar_dpath.sv
`timescale 1ns/1ps
module sar_dpath
  import sar_pkg::*;
#(
  parameter int WORD_W = 24,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              serData,
  input  sarStrobe_t        strb,
  input  logic [CNT_W-1:0]  bitIdx,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  logic [WORD_W-1:0] accWord;

  // One flop per word bit; bit i takes serData when the count points at it
  for (genvar i = 0; i < WORD_W; i++) begin : g_acc
    localparam logic [CNT_W-1:0] POS = CNT_W'(WORD_W - 1 - i);
    if (i == WORD_W - 1) begin : g_msb
      always_ff @(posedge serClk or negedge rstN) begin
        if (!rstN)               accWord[i] <= 1'b0;
        else if (strb.startSlot) accWord[i] <= serData;
      end
    end else begin : g_low
      always_ff @(posedge serClk or negedge rstN) begin
        if (!rstN)                                accWord[i] <= 1'b0;
        else if (strb.startSlot)                  accWord[i] <= 1'b0;
        else if (strb.loadBit && (bitIdx == POS)) accWord[i] <= serData;
      end
    end
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= strb.publish;
      if (strb.publish) wordOut <= accWord;
    end
  end
endmodule

// File: rtl/sar_word_rx.sv
`timescale 1ns/1ps
module sar_word_rx
  import sar_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int PCM_W  = 16,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              serClk,
  input  logic              rstN,
  input  logic              slotSync,
  input  logic              serData,
  input  logic              pcmMode,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  sarStrobe_t       strb;
  logic [CNT_W-1:0] bitIdx;

  sar_ctrl #(.WORD_W(WORD_W), .PCM_W(PCM_W)) u_ctrl (
    .serClk   (serClk),
    .rstN     (rstN),
    .slotSync (slotSync),
    .pcmMode  (pcmMode),
    .strb     (strb),
    .bitIdx   (bitIdx)
  );

  sar_dpath #(.WORD_W(WORD_W)) u_dpath (
    .serClk    (serClk),
    .rstN      (rstN),
    .serData   (serData),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .wordOut   (wordOut),
    .wordValid (wordValid)
  );
endmodule

// File: rtl/sar_chk.sv
`timescale 1ns/1ps
module sar_chk #(
  parameter int WORD_W = 24,
  parameter int PCM_W  = 16
) (
  input logic              serClk,
  input logic              rstN,
  input logic              slotSync,
  input logic              serData,
  input logic              pcmMode,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid
);
  localparam int LEN_W = $clog2(WORD_W + 2);
  localparam int SAT   = WORD_W + 1;

  logic              seenSync;
  logic [LEN_W-1:0]  slotLen, lastLen;
  logic              slotPcm, lastPcm;
  logic              slotFirst, lastFirst;
  logic [WORD_W-1:0] lowMask;
  int                effLen;

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      seenSync  <= 1'b0;
      slotLen   <= '0;
      lastLen   <= '0;
      slotPcm   <= 1'b0;
      lastPcm   <= 1'b0;
      slotFirst <= 1'b0;
      lastFirst <= 1'b0;
    end else if (slotSync) begin
      seenSync  <= 1'b1;
      lastLen   <= slotLen;
      lastPcm   <= slotPcm;
      lastFirst <= slotFirst;
      slotLen   <= LEN_W'(1);
      slotPcm   <= pcmMode;
      slotFirst <= serData;
    end else if (seenSync && (slotLen < LEN_W'(SAT))) begin
      slotLen   <= slotLen + LEN_W'(1);
    end
  end

  // Bits of the published word that must be zero-filled
  always_comb begin
    effLen = lastPcm ? PCM_W : WORD_W;
    if (int'(lastLen) < effLen) effLen = int'(lastLen);
    lowMask = WORD_W'((64'd1 << (WORD_W - effLen)) - 64'd1);
  end

  // R9
  valid_after_sync_chk: assert property (@(posedge serClk) disable iff (!rstN)
    wordValid |-> $past(slotSync));
  // R1
  no_early_valid_chk: assert property (@(posedge serClk) disable iff (!rstN)
    wordValid |-> $past(seenSync));
  // R9
  hold_word_chk: assert property (@(posedge serClk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));
  // R3
  zero_fill_chk: assert property (@(posedge serClk) disable iff (!rstN)
    wordValid |-> ((wordOut & lowMask) == '0));
  // R7
  pcm_low_zero_chk: assert property (@(posedge serClk) disable iff (!rstN)
    (wordValid && lastPcm) |-> (wordOut[WORD_W-PCM_W-1:0] == '0));
  // R2
  msb_first_chk: assert property (@(posedge serClk) disable iff (!rstN)
    wordValid |-> (wordOut[WORD_W-1] == lastFirst));
endmodule

bind sar_word_rx sar_chk #(.WORD_W(WORD_W), .PCM_W(PCM_W)) u_chk (
  .serClk    (serClk),
  .rstN      (rstN),
  .slotSync  (slotSync),
  .serData   (serData),
  .pcmMode   (pcmMode),
  .wordOut   (wordOut),
  .wordValid (wordValid)
);

// File: tb/tb_sar_word_rx.sv
`timescale 1ns/1ps
module tb_sar_word_rx;
  localparam int WORD_W = 24;
  localparam int PCM_W  = 16;

  logic              serClk = 1'b0;
  logic              rstN;
  logic              slotSync;
  logic              serData;
  logic              pcmMode;
  logic [WORD_W-1:0] wordOut;
  logic              wordValid;

  int checks = 0;
  int fails  = 0;
  bit havePend = 1'b0;
  logic [WORD_W-1:0] expPend;
  string tagPend;

  always #4 serClk = ~serClk;

  sar_word_rx #(.WORD_W(WORD_W), .PCM_W(PCM_W)) dut (
    .serClk(serClk), .rstN(rstN), .slotSync(slotSync), .serData(serData),
    .pcmMode(pcmMode), .wordOut(wordOut), .wordValid(wordValid)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [WORD_W-1:0] model(input int n, input longint unsigned src, input bit pcm);
    int lim = pcm ? PCM_W : WORD_W;
    int eff = (n < lim) ? n : lim;
    longint unsigned top = src >> (n - eff);
    return WORD_W'(top << (WORD_W - eff));
  endfunction

  // Send one slot of n bits; src bit n-1 goes first. pcmMode flips from bit flipAt on.
  task automatic sendSlot(input int n, input longint unsigned src, input bit pcm,
                          input int flipAt, input string tag);
    logic [WORD_W-1:0] heldWord;
    for (int i = 0; i < n; i++) begin
      @(negedge serClk);
      slotSync = (i == 0);
      serData  = src[n-1-i];
      pcmMode  = (flipAt >= 0 && i >= flipAt) ? ~pcm : pcm;
      @(posedge serClk);
      #1;
      if (i == 0) begin
        if (havePend) begin
          check(wordValid === 1'b1, {tagPend, " valid"}, wordValid, 1);
          check(wordOut === expPend, tagPend, wordOut, expPend);
        end else begin
          check(wordValid === 1'b0, "R1 no valid before first slot closes", wordValid, 0);
        end
        heldWord = wordOut;
      end else if (i == 1) begin
        check(wordValid === 1'b0, "R9 one-cycle valid", wordValid, 0);
        check(wordOut === heldWord, "R9 word held", wordOut, heldWord);
      end
    end
    havePend = 1'b1;
    expPend  = model(n, src, pcm);
    tagPend  = tag;
  endtask

  function automatic string sweepTag(input int n, input bit pcm);
    if (pcm) return "R7";
    if (n < WORD_W) return "R3";
    if (n == WORD_W) return "R4";
    return "R5";
  endfunction

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint unsigned lcg = 64'h1234_5678_9abc_def1;
    rstN = 1'b0; slotSync = 1'b0; serData = 1'b0; pcmMode = 1'b0;
    repeat (3) @(posedge serClk);
    #1;
    check(wordOut === '0, "R1 reset word", wordOut, 0);
    check(wordValid === 1'b0, "R1 reset valid", wordValid, 0);
    @(negedge serClk);
    serData = 1'b1;
    rstN = 1'b1;
    repeat (3) @(posedge serClk);
    #1;
    check(wordValid === 1'b0 && wordOut === '0, "R1 idle after reset", wordOut, 0);

    // R2: single-bit slot lands in the MSB
    sendSlot(1, 64'h1, 1'b0, -1, "R2");
    // R6: 16 data bits plus 4 padding ones, 20 clocks
    sendSlot(20, (64'hBEEF << 4) | 64'hF, 1'b0, -1, "R6");
    // R8: mode flips mid-slot have no effect
    sendSlot(24, 64'hFFFFFF, 1'b1, 10, "R8 pcm kept");
    sendSlot(24, 64'hFFFFFF, 1'b0, 10, "R8 wide kept");
    sendSlot(30, 64'h3FFF_FFFF, 1'b1, 5, "R8 pcm overlong");

    // Sweep lengths 1..30, both modes, three patterns
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 3; p++) begin
        for (int n = 1; n <= 30; n++) begin
          longint unsigned msk = (64'd1 << n) - 64'd1;
          longint unsigned src;
          if (p == 0) src = msk;
          else if (p == 1) src = 64'hAAAA_AAAA_AAAA_AAAA & msk;
          else begin
            lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
            src = (lcg >> 20) & msk;
          end
          sendSlot(n, src, m[0], -1, sweepTag(n, m[0]));
        end
      end
    end
    // Closing sync publishes the last slot
    sendSlot(1, 64'h0, 1'b0, -1, "R2");
    repeat (2) @(posedge serClk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule